// File: doc/BRIEF.md
# Banked Interrupt Mask and Status Register File

This block collects 72 level-sensitive interrupt sources. There are eight basic sources and two banks of 32 peripheral sources. It holds one enable bit per source and shows the enabled, pending sources through three read-only status words on a plain 32-bit register bus.

Software never writes a mask word directly. A write to a set offset turns on the enable bit for every 1 in the data. A write to a clear offset turns off the enable bit for every 1 in the data. Because of this, drivers that share a bank cannot undo each other's bits.

The basic status word gives a quick view of everything in one read:
- its own eight sources;
- one summary bit per bank;
- direct copies of eleven selected bank sources, so a handler can often skip reading a bank word.

A single `irq_o` line is the OR of every enabled, pending source. A 32-bit fast-interrupt routing word is kept as a plain read/write register and has no other function here. Priority resolution is left to software.

Top module: `irq_bank_regfile`

## Requirements
- R1: Register map (byte offsets, `addr_i[1:0]` ignored):
  - basic status 0x00, bank-A status 0x04, bank-B status 0x08;
  - routing word 0x0C;
  - set offsets: bank-A 0x10, bank-B 0x14, basic 0x18;
  - clear offsets: bank-A 0x1C, bank-B 0x20, basic 0x24.
  - Offsets 0x28 to 0x3C read as zero.
- R2: A write to a set offset sets each mask bit whose data bit is 1. All other mask bits keep their value. The new mask is visible from the cycle after the write edge.
- R3: A write to a clear offset clears each mask bit whose data bit is 1. All other mask bits keep their value.
- R4: After `rst_ni` is asserted, all three masks and the routing word are zero.
- R5: Bank-A status at 0x04 reads `src_bank_a_i & mask_a`. Bank-B status at 0x08 reads `src_bank_b_i & mask_b`. Both are combinational in the current sources.
- R6: Basic status bits [7:0] are `src_basic_i & mask_basic`. Bits [31:21] read as zero.
- R7: Basic status bit 8 is the OR of all enabled, pending bank-A sources. Bit 9 is the same for bank-B.
- R8: Basic status copies of enabled, pending bank sources:
  - bits 10..14 copy bank-A sources 7, 9, 10, 18 and 19;
  - bits 15..20 copy bank-B sources 21, 22, 23, 24, 25 and 30.
- R9: `irq_o` is 1 exactly when at least one enabled source of the 72 is active.
- R10: The routing word at 0x0C stores any written 32-bit value and reads it back.
- R11: Reads of a set or clear offset return that group's current mask, zero-extended for the basic group. Writes to the status offsets or to unmapped offsets change no mask and not the routing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 6 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational from `addr_i`) |
| src_basic_i | input | 8 | Basic source levels |
| src_bank_a_i | input | 32 | Bank-A source levels |
| src_bank_b_i | input | 32 | Bank-B source levels |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions make two assumptions about the inputs:
- `we_i` is only high when `addr_i` and `wdata_i` are defined;
- the source inputs may change in any cycle, so every status relation is checked in the same cycle with no delay.

The bench keeps to these assumptions by driving every input at the falling edge and sampling combinational reads one nanosecond later. Random writes fall on the whole address range, including the status and unmapped offsets. The bench keeps its own model of the masks and the routing word.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BASIC_N = 8;
  localparam int unsigned BANK_N  = 32;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned CUT_A_N = 5;
  localparam int unsigned CUT_B_N = 6;

  // word index = byte offset >> 2
  typedef enum logic [3:0] {
    W_STAT_BASIC = 4'd0,
    W_STAT_A     = 4'd1,
    W_STAT_B     = 4'd2,
    W_ROUTE      = 4'd3,
    W_SET_A      = 4'd4,
    W_SET_B      = 4'd5,
    W_SET_BASIC  = 4'd6,
    W_CLR_A      = 4'd7,
    W_CLR_B      = 4'd8,
    W_CLR_BASIC  = 4'd9
  } reg_idx_e;

  localparam int unsigned CUT_A_SRC [CUT_A_N] = '{7, 9, 10, 18, 19};
  localparam int unsigned CUT_B_SRC [CUT_B_N] = '{21, 22, 23, 24, 25, 30};
  localparam int unsigned SUM_A_BIT = BASIC_N;
  localparam int unsigned SUM_B_BIT = BASIC_N + 1;
  localparam int unsigned CUT_A_LO  = BASIC_N + 2;
  localparam int unsigned CUT_B_LO  = CUT_A_LO + CUT_A_N;
  localparam int unsigned STAT_USED = CUT_B_LO + CUT_B_N;
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (set_i) mask_q <= mask_q | data_i;
    else if (clr_i) mask_q <= mask_q & ~data_i;
  end

  assign mask_o = mask_q;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((mask_q & $past(data_i)) == $past(data_i))
              && ((mask_q & ~$past(data_i)) == ($past(mask_q) & ~$past(data_i))));
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((mask_q & $past(data_i)) == '0)
              && ((mask_q & ~$past(data_i)) == ($past(mask_q) & ~$past(data_i))));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(mask_q));
endmodule

// File: rtl/irqc_basic_status.sv
module irqc_basic_status
  import irqc_pkg::*;
(
  input  logic [BASIC_N-1:0] pend_basic_i,
  input  logic [BANK_N-1:0]  pend_a_i,
  input  logic [BANK_N-1:0]  pend_b_i,
  output logic [DATA_W-1:0]  stat_o
);
  logic [CUT_A_N-1:0] cut_a;
  logic [CUT_B_N-1:0] cut_b;

  for (genvar i = 0; i < CUT_A_N; i++) begin : g_cut_a
    assign cut_a[i] = pend_a_i[CUT_A_SRC[i]];
  end
  for (genvar i = 0; i < CUT_B_N; i++) begin : g_cut_b
    assign cut_b[i] = pend_b_i[CUT_B_SRC[i]];
  end

  assign stat_o = {{(DATA_W-STAT_USED){1'b0}}, cut_b, cut_a,
                   |pend_b_i, |pend_a_i, pend_basic_i};
endmodule

// File: rtl/irq_bank_regfile.sv
module irq_bank_regfile
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [BASIC_N-1:0] src_basic_i,
  input  logic [BANK_N-1:0]  src_bank_a_i,
  input  logic [BANK_N-1:0]  src_bank_b_i,
  output logic              irq_o
);
  localparam int unsigned NBANK = 2;

  logic [3:0]              widx;
  logic [BASIC_N-1:0]      mask_basic;
  logic [NBANK-1:0][BANK_N-1:0] mask_bank, src_bank, pend_bank;
  logic [NBANK-1:0]        set_bank, clr_bank;
  logic [BASIC_N-1:0]      pend_basic;
  logic [DATA_W-1:0]       stat_basic;
  logic [DATA_W-1:0]       route_q;

  assign widx        = addr_i[ADDR_W-1:2];
  assign src_bank[0] = src_bank_a_i;
  assign src_bank[1] = src_bank_b_i;
  assign set_bank[0] = we_i && (widx == W_SET_A);
  assign set_bank[1] = we_i && (widx == W_SET_B);
  assign clr_bank[0] = we_i && (widx == W_CLR_A);
  assign clr_bank[1] = we_i && (widx == W_CLR_B);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irqc_mask_reg #(.W(BANK_N)) u_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_bank[b]),
      .clr_i  (clr_bank[b]),
      .data_i (wdata_i[BANK_N-1:0]),
      .mask_o (mask_bank[b])
    );
    assign pend_bank[b] = src_bank[b] & mask_bank[b];
  end

  irqc_mask_reg #(.W(BASIC_N)) u_mask_basic (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (we_i && (widx == W_SET_BASIC)),
    .clr_i  (we_i && (widx == W_CLR_BASIC)),
    .data_i (wdata_i[BASIC_N-1:0]),
    .mask_o (mask_basic)
  );
  assign pend_basic = src_basic_i & mask_basic;

  irqc_basic_status u_stat (
    .pend_basic_i (pend_basic),
    .pend_a_i     (pend_bank[0]),
    .pend_b_i     (pend_bank[1]),
    .stat_o       (stat_basic)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        route_q <= '0;
    else if (we_i && widx == W_ROUTE)   route_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    case (widx)
      W_STAT_BASIC:             rdata_o = stat_basic;
      W_STAT_A:                 rdata_o = pend_bank[0];
      W_STAT_B:                 rdata_o = pend_bank[1];
      W_ROUTE:                  rdata_o = route_q;
      W_SET_A, W_CLR_A:         rdata_o = mask_bank[0];
      W_SET_B, W_CLR_B:         rdata_o = mask_bank[1];
      W_SET_BASIC, W_CLR_BASIC: rdata_o = {{(DATA_W-BASIC_N){1'b0}}, mask_basic};
      default:                  rdata_o = '0;
    endcase
  end

  assign irq_o = |{pend_basic, pend_bank};

  p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|stat_basic[SUM_B_BIT:0]));
  p_sum_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_basic[SUM_A_BIT] == |(src_bank_a_i & mask_bank[0]))
    && (stat_basic[SUM_B_BIT] == |(src_bank_b_i & mask_bank[1])));
  p_cut_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_basic[CUT_A_LO] == (src_bank_a_i[7] & mask_bank[0][7]))
    && (stat_basic[STAT_USED-1] == (src_bank_b_i[30] & mask_bank[1][30])));
  p_hi_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (widx == W_STAT_BASIC) |-> (rdata_o[DATA_W-1:STAT_USED] == '0));
  p_route_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx == W_ROUTE) |=> (route_q == $past(wdata_i)));
  p_route_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && widx == W_ROUTE) |=> $stable(route_q));
endmodule

// File: tb/irq_bank_regfile_tb_top.sv
`timescale 1ns/1ps
module irq_bank_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  s_basic = '0;
  logic [31:0] s_a = '0, s_b = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_basic = '0;
  logic [31:0] m_a = '0, m_b = '0, m_route = '0;

  always #2.5 clk = ~clk;

  irq_bank_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .src_basic_i(s_basic), .src_bank_a_i(s_a),
    .src_bank_b_i(s_b), .irq_o(irq)
  );

  function automatic logic [31:0] exp_basic();
    logic [31:0] pa, pb, r;
    pa = s_a & m_a;
    pb = s_b & m_b;
    r = '0;
    r[7:0] = s_basic & m_basic;
    r[8]  = |pa;
    r[9]  = |pb;
    r[10] = pa[7];  r[11] = pa[9];  r[12] = pa[10]; r[13] = pa[18]; r[14] = pa[19];
    r[15] = pb[21]; r[16] = pb[22]; r[17] = pb[23]; r[18] = pb[24]; r[19] = pb[25];
    r[20] = pb[30];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    case (a[5:2])
      4'd0: return exp_basic();
      4'd1: return s_a & m_a;
      4'd2: return s_b & m_b;
      4'd3: return m_route;
      4'd4, 4'd7: return m_a;
      4'd5, 4'd8: return m_b;
      4'd6, 4'd9: return {24'd0, m_basic};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a[5:2])
      4'd0: return "R6/R7/R8";
      4'd1, 4'd2: return "R5";
      4'd3: return "R10";
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
    case (a[5:2])
      4'd3: m_route = d;
      4'd4: m_a = m_a | d;
      4'd5: m_b = m_b | d;
      4'd6: m_basic = m_basic | d[7:0];
      4'd7: m_a = m_a & ~d;
      4'd8: m_b = m_b & ~d;
      4'd9: m_basic = m_basic & ~d[7:0];
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [5:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    addr = a;
    #1;
    e = exp_read(a);
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", tag, a, rdata, e);
    end
  endtask

  task automatic irq_chk();
    logic e;
    #1;
    e = (|(s_basic & m_basic)) | (|(s_a & m_a)) | (|(s_b & m_b));
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL R9 irq actual=%0b expected=%0b", irq, e);
    end
  endtask

  task automatic all_regs();
    for (int i = 0; i < 16; i++) rd_chk(6'(i * 4), tag_of(6'(i * 4)));
    irq_chk();
  endtask

  task automatic set_src(input logic [7:0] b, input logic [31:0] a, input logic [31:0] c);
    @(negedge clk);
    s_basic = b; s_a = a; s_b = c;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R4: reset state, all sources active but nothing enabled
    set_src(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) rd_chk(6'(i * 4), "R4");
    irq_chk();

    // R2: set basic bit 3, bank-A shortcut 9, bank-B shortcut 30
    wr(6'h18, 32'h0000_0108);
    rd_chk(6'h18, "R2");
    wr(6'h10, 32'h0000_0200);
    wr(6'h14, 32'h4000_0000);
    rd_chk(6'h10, "R2");
    rd_chk(6'h00, "R8");
    rd_chk(6'h04, "R5");
    rd_chk(6'h08, "R5");
    irq_chk();
    // R7: non-shortcut bank-A source 0 alone
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFF);
    rd_chk(6'h14, "R3");
    rd_chk(6'h24, "R3");
    wr(6'h10, 32'h0000_0001);
    set_src(8'h00, 32'h0000_0001, 32'h0);
    rd_chk(6'h00, "R7");
    irq_chk();
    set_src(8'h00, 32'h0, 32'h0);
    rd_chk(6'h00, "R7");
    irq_chk();
    // R8: every shortcut on, bits 21..31 zero (R6)
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    set_src(8'h00, 32'h000C_0680, 32'h43E0_0000);
    rd_chk(6'h00, "R8");
    set_src(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd_chk(6'h00, "R6");
    // R10: routing word
    wr(6'h0C, 32'hDEAD_BEEF);
    rd_chk(6'h0C, "R10");
    // R11: writes to status and unmapped offsets change nothing
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h04, 32'h0);
    wr(6'h2C, 32'hFFFF_FFFF);
    wr(6'h3C, 32'h0);
    all_regs();
    // R1: unmapped offsets and ignored low address bits
    rd_chk(6'h28, "R1");
    rd_chk(6'h3D, "R1");
    rd_chk(6'h0E, "R1");

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic [5:0] a;
      logic [31:0] d;
      a = 6'($urandom_range(0, 15) * 4);
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = d & $urandom();
      wr(a, d);
      set_src(8'($urandom()), $urandom() & $urandom(), $urandom() & $urandom());
      if (it % 4 == 0) all_regs();
      else begin
        rd_chk(6'h00, "R8");
        rd_chk(a, tag_of(a));
        irq_chk();
      end
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule